// File: doc/BRIEF.md
# Crossbar Routing Source Selector

This block decides where the crossbar switch takes its routing configuration from. After reset the routing comes from a six-bit code on hardware select pins, which is sampled once and then held. Software on the serial configuration bus can take over by writing a fixed key value to a key address. From then on the routing comes from two 8-bit routing registers, and the pins are ignored.

The handover is one-way. Only reset or the power-down input returns control to the pins. Power-down also arms a fresh pin sample, which is taken when power-down is released. The pin sample is taken only at those release points and does not follow the pins at other times. Decoding the active word into individual crossbar connections is left to the switch.

Top module: `route_src_sel`

## Requirements
- R1: While `rst` is high the block is in pin mode with both routing registers cleared. In the first clock edge with `rst` and `pwr_down` both low, the six select pins are captured. From the next cycle `route_cfg` shows them.
- R2: In pin mode `route_from_regs` is 0 and `route_cfg` is the captured pin code in bits [5:0], with bits [15:6] zero.
- R3: In pin mode, changing the select pins without a reset or power-down cycle leaves `route_cfg` unchanged.
- R4: A write of data 0xFF to address 0xFF switches to register mode from the cycle after the write edge. In register mode `route_from_regs` is 1 and `route_cfg` is {register 0x02, register 0x01}: register 0x02 is in bits [15:8] and register 0x01 in bits [7:0].
- R5: A write to address 0xFF with any data other than 0xFF leaves the source unchanged, in either mode.
- R6: In register mode the select pins have no effect. A write to address 0x01 or 0x02 appears on `route_cfg` in the cycle after the write edge.
- R7: Writes to addresses 0x01 and 0x02 made in pin mode are stored but do not alter `route_cfg` until the handover.
- R8: Writes to any address other than 0x01, 0x02 and 0xFF change neither register contents nor the output.
- R9: A clock edge with `pwr_down` high returns the block to pin mode, and `route_cfg` shows the previously captured pins. On the first edge with `pwr_down` low again, the pins are re-sampled.
- R10: Writes presented while `pwr_down` or `rst` is high are ignored, including the key write.
- R11: The routing registers keep their contents through a power-down cycle. A later handover presents the values written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pins | input | 6 | Hardware routing select code |
| pwr_down | input | 1 | Power-down control, high = powered down |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| route_from_regs | output | 1 | 1 when the routing registers are the active source |
| route_cfg | output | 16 | Active routing word presented to the switch |

## Verification
The scoreboard compares both outputs after every edge across several kinds of input. Pin changes with no release event separate a held sample from a live pin path. Near-miss key writes, with the right address and wrong data, or writes to unused addresses, separate a full key decode from a partial one. Power-down cycles with writes and pin changes applied during them show three things: the latch is cleared, the new pin sample is taken at release rather than at entry, and the register contents survive while writes are blocked. A final reset followed by a handover shows that reset clears the registers, unlike power-down.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

    localparam int RSEL_ADDR_W = 8;
    localparam int RSEL_DATA_W = 8;

    typedef enum logic {
        SRC_PINS = 1'b0,
        SRC_REGS = 1'b1
    } route_src_e;

    typedef struct packed {
        logic                   en;
        logic [RSEL_ADDR_W-1:0] addr;
        logic [RSEL_DATA_W-1:0] data;
    } cfg_wr_t;

    // True when a write carries the handover key at the key address
    function automatic logic is_key_write(input cfg_wr_t w,
                                          input logic [RSEL_ADDR_W-1:0] key_addr,
                                          input logic [RSEL_DATA_W-1:0] key_val);
        return w.en && (w.addr == key_addr) && (w.data == key_val);
    endfunction

    // True when a write targets the key address with any other data
    function automatic logic is_key_miss(input cfg_wr_t w,
                                         input logic [RSEL_ADDR_W-1:0] key_addr,
                                         input logic [RSEL_DATA_W-1:0] key_val);
        return w.en && (w.addr == key_addr) && (w.data != key_val);
    endfunction

endpackage

// File: rtl/rsel_pin_capture.sv
module rsel_pin_capture #(
    parameter int PIN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_down,
    input  logic [PIN_W-1:0] pins,
    output logic [PIN_W-1:0] pin_q
);
    // Armed by reset or power-down, fires once on the first free edge
    logic arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b1;
            pin_q <= '0;
        end else if (pwr_down) begin
            arm_q <= 1'b1;
        end else if (arm_q) begin
            arm_q <= 1'b0;
            pin_q <= pins;
        end
    end

    // R3: once disarmed the sample holds regardless of the pins
    p_pin_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !arm_q |=> $stable(pin_q));

    // R9: power-down always re-arms the sampler
    p_pd_arms_r9: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> arm_q);

    // R9: an armed sampler takes the pins on the first free edge
    p_capture_r9: assert property (@(posedge clk) disable iff (rst)
        (arm_q && !pwr_down) |=> (pin_q == $past(pins)));

endmodule

// File: rtl/rsel_reg_bank.sv
module rsel_reg_bank
    import rsel_pkg::*;
#(
    parameter int NUM_REGS  = 2,
    parameter int BASE_ADDR = 1,
    localparam int FLAT_W   = NUM_REGS * RSEL_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_wr_t           wr,
    output logic [FLAT_W-1:0] regs_flat
);
    logic [NUM_REGS-1:0] hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [RSEL_ADDR_W-1:0] MY_ADDR = RSEL_ADDR_W'(BASE_ADDR + g);

        assign hit[g] = wr.en && (wr.addr == MY_ADDR);

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_flat[g*RSEL_DATA_W +: RSEL_DATA_W] <= '0;
            end else if (hit[g]) begin
                regs_flat[g*RSEL_DATA_W +: RSEL_DATA_W] <= wr.data;
            end
        end
    end

    // R8: no addressed routing register, no change in contents
    p_reg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |=> $stable(regs_flat));

    // R6: at most one register decodes a given address
    p_one_hit_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

endmodule

// File: rtl/rsel_src_latch.sv
module rsel_src_latch
    import rsel_pkg::*;
#(
    parameter logic [RSEL_ADDR_W-1:0] KEY_ADDR = 8'hFF,
    parameter logic [RSEL_DATA_W-1:0] KEY_VAL  = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_down,
    input  cfg_wr_t    wr,
    output route_src_e src
);
    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            src <= SRC_PINS;
        end else if (is_key_write(wr, KEY_ADDR, KEY_VAL)) begin
            src <= SRC_REGS;
        end
    end

    // R9: power-down always drops register control
    p_pd_clears_r9: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (src == SRC_PINS));

    // R5: a key-address write with other data leaves the source alone
    p_bad_key_r5: assert property (@(posedge clk) disable iff (rst)
        (is_key_miss(wr, KEY_ADDR, KEY_VAL) && !pwr_down) |=> $stable(src));

    // R4: the handover is one-way without power-down
    p_one_way_r4: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_REGS && !pwr_down) |=> (src == SRC_REGS));

endmodule

// File: rtl/route_src_sel.sv
module route_src_sel
    import rsel_pkg::*;
#(
    parameter int PIN_W       = 6,
    parameter int NUM_REGS    = 2,
    parameter int BASE_ADDR   = 1,
    parameter logic [RSEL_ADDR_W-1:0] KEY_ADDR = 8'hFF,
    parameter logic [RSEL_DATA_W-1:0] KEY_VAL  = 8'hFF,
    localparam int ROUTE_W    = NUM_REGS * RSEL_DATA_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PIN_W-1:0]       sel_pins,
    input  logic                   pwr_down,
    input  logic                   wr_en,
    input  logic [RSEL_ADDR_W-1:0] wr_addr,
    input  logic [RSEL_DATA_W-1:0] wr_data,
    output logic                   route_from_regs,
    output logic [ROUTE_W-1:0]     route_cfg
);
    cfg_wr_t            wr_gated;
    logic [PIN_W-1:0]   pin_q;
    logic [ROUTE_W-1:0] reg_word;
    route_src_e         src;

    // Writes are blocked while powered down
    always_comb begin
        wr_gated.en   = wr_en && !pwr_down;
        wr_gated.addr = wr_addr;
        wr_gated.data = wr_data;
    end

    rsel_pin_capture #(
        .PIN_W (PIN_W)
    ) u_pins (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .pins     (sel_pins),
        .pin_q    (pin_q)
    );

    rsel_reg_bank #(
        .NUM_REGS  (NUM_REGS),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_gated),
        .regs_flat (reg_word)
    );

    rsel_src_latch #(
        .KEY_ADDR (KEY_ADDR),
        .KEY_VAL  (KEY_VAL)
    ) u_src (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .wr       (wr_gated),
        .src      (src)
    );

    always_comb begin
        route_from_regs = (src == SRC_REGS);
        if (src == SRC_REGS) begin
            route_cfg = reg_word;
        end else begin
            route_cfg = {{(ROUTE_W-PIN_W){1'b0}}, pin_q};
        end
    end

    // R10: nothing written while powered down reaches the registers
    p_pd_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> $stable(reg_word));

    // R4: register mode is entered only after a live key write
    p_rise_needs_key_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(route_from_regs) |->
            $past(wr_en && !pwr_down && wr_addr == KEY_ADDR && wr_data == KEY_VAL));

    // R2: in pin mode the upper routing bits are zero
    p_pin_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !route_from_regs |-> (route_cfg[ROUTE_W-1:PIN_W] == '0));

endmodule

// File: tb/route_src_sel_tb.sv
module route_src_sel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  sel_pins;
    logic        pwr_down;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        route_from_regs;
    logic [15:0] route_cfg;

    always #2 clk = ~clk;

    route_src_sel u_dut (
        .clk             (clk),
        .rst             (rst),
        .sel_pins        (sel_pins),
        .pwr_down        (pwr_down),
        .wr_en           (wr_en),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data),
        .route_from_regs (route_from_regs),
        .route_cfg       (route_cfg)
    );

    typedef struct {
        logic        mode;
        logic [15:0] cfg;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // Reference model state
    logic       m_mode = 1'b0;
    logic [7:0] m_r1   = '0;
    logic [7:0] m_r2   = '0;
    logic       m_arm  = 1'b1;
    logic [5:0] m_pin  = '0;

    task automatic step(input logic r, input logic pd, input logic [5:0] p,
                        input logic we, input logic [7:0] a, input logic [7:0] d,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; pwr_down = pd; sel_pins = p;
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        if (r) begin
            m_mode = 1'b0; m_r1 = '0; m_r2 = '0; m_arm = 1'b1; m_pin = '0;
        end else if (pd) begin
            m_arm = 1'b1; m_mode = 1'b0;
        end else begin
            if (m_arm) begin
                m_pin = p; m_arm = 1'b0;
            end
            if (we && a == 8'h01) m_r1 = d;
            if (we && a == 8'h02) m_r2 = d;
            if (we && a == 8'hFF && d == 8'hFF) m_mode = 1'b1;
        end
        e.mode = m_mode;
        e.cfg  = m_mode ? {m_r2, m_r1} : {10'b0, m_pin};
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares after every edge, away from the edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (route_from_regs !== e.mode || route_cfg !== e.cfg) begin
                n_fail++;
                $display("FAIL %s: got mode=%0b cfg=%04h, expected mode=%0b cfg=%04h",
                         e.tag, route_from_regs, route_cfg, e.mode, e.cfg);
            end
        end
    end

    initial begin
        rst = 1'b1; pwr_down = 1'b0; sel_pins = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;

        // R1: reset state, then the pin sample at release
        step(1, 0, 6'h15, 0, 8'h00, 8'h00, "R1 reset");
        step(1, 0, 6'h15, 0, 8'h00, 8'h00, "R1 reset");
        step(0, 0, 6'h15, 0, 8'h00, 8'h00, "R1 capture");
        step(0, 0, 6'h15, 0, 8'h00, 8'h00, "R2 pin word");
        // R3: pins move, routing holds
        step(0, 0, 6'h2A, 0, 8'h00, 8'h00, "R3 pins ignored");
        step(0, 0, 6'h3F, 0, 8'h00, 8'h00, "R3 pins ignored");
        // R7: routing registers written in pin mode
        step(0, 0, 6'h2A, 1, 8'h01, 8'hA5, "R7 store r1");
        step(0, 0, 6'h2A, 1, 8'h02, 8'h3C, "R7 store r2");
        // R8 / R5: unused address and wrong key data
        step(0, 0, 6'h2A, 1, 8'h05, 8'h77, "R8 other addr");
        step(0, 0, 6'h2A, 1, 8'hFF, 8'hFE, "R5 bad key");
        step(0, 0, 6'h2A, 1, 8'h7F, 8'hFF, "R5 key data wrong addr");
        // R4: handover
        step(0, 0, 6'h2A, 1, 8'hFF, 8'hFF, "R4 handover");
        step(0, 0, 6'h2A, 0, 8'h00, 8'h00, "R4 reg word");
        // R6: pins ignored, register updates visible
        step(0, 0, 6'h01, 0, 8'h00, 8'h00, "R6 pins ignored");
        step(0, 0, 6'h01, 1, 8'h01, 8'h5A, "R6 r1 update");
        step(0, 0, 6'h01, 1, 8'h00, 8'h99, "R8 addr 0 ignored");
        step(0, 0, 6'h01, 1, 8'hFF, 8'h00, "R5 bad key in reg mode");
        step(0, 0, 6'h01, 0, 8'h00, 8'h00, "R5 still regs");
        // R9 / R10: power-down with writes and pin changes
        step(0, 1, 6'h2A, 1, 8'h02, 8'h11, "R9 pd clears");
        step(0, 1, 6'h2A, 1, 8'hFF, 8'hFF, "R10 key blocked in pd");
        step(0, 1, 6'h2A, 1, 8'h01, 8'h22, "R10 write blocked in pd");
        step(0, 0, 6'h2A, 0, 8'h00, 8'h00, "R9 resample");
        step(0, 0, 6'h07, 0, 8'h00, 8'h00, "R3 held after resample");
        // R11: registers survive power-down
        step(0, 0, 6'h07, 1, 8'hFF, 8'hFF, "R11 retained");
        step(0, 0, 6'h07, 0, 8'h00, 8'h00, "R11 retained");
        // R10: writes during reset are ignored, registers cleared
        step(1, 0, 6'h33, 1, 8'h01, 8'hEE, "R10 write in reset");
        step(0, 0, 6'h33, 0, 8'h00, 8'h00, "R1 capture after reset");
        step(0, 0, 6'h33, 1, 8'hFF, 8'hFF, "R1 regs cleared");
        step(0, 0, 6'h33, 1, 8'h02, 8'h80, "R6 r2 update");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    // Watchdog
    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule